// File: doc/BRIEF.md
# Nested-Loop Descriptor DMA Channel

This block is one DMA channel steered by a transfer descriptor. The descriptor holds these fields:

- a source address and a destination address;
- signed per-access steps for each address;
- access-size codes for each side;
- a minor-loop byte count;
- a current and a beginning iteration count;
- signed address corrections applied when the major loop ends;
- an interrupt enable;
- a software start bit.

Each activation moves exactly one minor loop of bytes through a simple single-port memory interface, then returns to idle. A hardware request, when enabled, causes the activation. So does the software start bit.

Data passes through a small byte stash. This lets a channel read in one element size and write in another. For example, it can gather four byte reads into one 32-bit write, or scatter one word read into four byte writes.

The major loop ends when the iteration count is exhausted. At that point the channel does four things:

- applies the end-of-major corrections to both addresses;
- reloads the current count from the beginning count;
- clears the start bit;
- raises a done flag, plus an interrupt if enabled.

Top module: `dma_nest_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `done`, `irq`, `err`, `mem_rd` and `mem_wr` are all low.
- R2: One activation performs exactly one minor loop. It issues minor_bytes / destination-size writes, and `busy` is low in the cycle after the last write.
- R3: After each read the source address advances by the sign-extended source step. After each write the destination address advances by the sign-extended destination step. Negative steps move downward.
- R4: Size codes are 3 bits wide: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. `mem_size` carries the code of the current access. Data is little-endian: byte k of the minor loop comes from source byte k and lands at destination byte k, whatever the two sizes are.
- R5: A minor-byte count of 0 stands for 2^32 bytes, so the channel stays busy far beyond any short transfer.
- R6: At major-loop end, the signed source correction is added to the source address and the signed destination correction to the destination address. A correction of 0 leaves the address where it stopped.
- R7: The current iteration count drops by one per minor loop. The major loop ends on the minor loop that starts with a count of 1 (or 0). The count is then reloaded from the beginning count.
- R8: At major-loop end `done` is set. `irq` is set only if the descriptor's interrupt enable is 1. Both flags are cleared when the next activation starts or when a descriptor is written.
- R9: A `sw_start` pulse sets the start bit. It starts service with no hardware request. The bit stays set until major-loop end, so every minor loop of the major loop runs, and the bit is cleared at the end.
- R10: `hw_req` activates the channel only while `req_en` is 1.
- R11: A size code above 2, or a minor-byte count that is not a multiple of both sizes, sets `err` on activation. In that case there is no memory access and the start bit is cleared.
- R12: A descriptor write is accepted only while the channel is idle. A write while busy has no effect on the transfer in progress.
- R13: A read gets its data on `mem_rdata` in the following cycle. No read or write is issued in that cycle, and a read and a write never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsc_wr | input | 1 | Load descriptor fields (idle only) |
| dsc_src | input | AW | Source address |
| dsc_dst | input | AW | Destination address |
| dsc_src_step | input | OFFW | Signed source step per read |
| dsc_dst_step | input | OFFW | Signed destination step per write |
| dsc_src_size | input | 3 | Source size code |
| dsc_dst_size | input | 3 | Destination size code |
| dsc_minor_bytes | input | 32 | Bytes per minor loop (0 = 2^32) |
| dsc_src_last | input | AW | Signed source correction at major end |
| dsc_dst_last | input | AW | Signed destination correction at major end |
| dsc_iter_cur | input | ITW | Current iteration count |
| dsc_iter_begin | input | ITW | Beginning iteration count |
| dsc_irq_en | input | 1 | Interrupt on major-loop end |
| dsc_start | input | 1 | Start bit value loaded with descriptor |
| sw_start | input | 1 | Pulse that sets the start bit |
| req_en | input | 1 | Hardware request enable |
| hw_req | input | 1 | Hardware request |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Access address |
| mem_size | output | 3 | Access size code |
| mem_wdata | output | DW | Write data, low bytes used |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop finished |
| irq | output | 1 | Interrupt request |
| err | output | 1 | Configuration error |

## Verification
The main transfer is tried with four patterns:

- byte-to-byte, with positive steps;
- byte reads packed into word writes;
- word reads split into byte writes;
- halfword accesses with a negative source step.

Comparing the destination image against the source pattern separates a wrong byte order from a wrong address step, and the logged address traces pin down each step on its own. A four-loop run with non-zero corrections shows both the end-of-major address jump and the count reload. A software-started run shows the start bit carrying a whole major loop and then clearing itself.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RDW  = 2'd2
    } dnc_state_e;
endpackage

// File: rtl/dnc_size_dec.sv
module dnc_size_dec #(
    parameter int NB = 4,
    localparam int LOG_NB = $clog2(NB),
    localparam int CW = LOG_NB + 1
) (
    input  logic [2:0]    code,
    output logic [CW-1:0] nbytes,
    output logic          ok
);
    always_comb begin
        ok     = (int'(code) <= LOG_NB);
        nbytes = ok ? (CW'(1) << code) : CW'(1);
    end
endmodule

// File: rtl/dnc_addr_step.sv
module dnc_addr_step #(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] off,
    output logic [AW-1:0]   sum
);
    generate
        if (OFFW < AW) begin : g_ext
            assign sum = base + {{(AW-OFFW){off[OFFW-1]}}, off};
        end else begin : g_full
            assign sum = base + off[AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/dnc_lane_buf.sv
module dnc_lane_buf #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int CW = $clog2(NB) + 1
) (
    input  logic [DW-1:0] stash,
    input  logic [DW-1:0] rdata,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] rd_bytes,
    input  logic [CW-1:0] wr_bytes,
    output logic [DW-1:0] stash_ins,
    output logic [DW-1:0] stash_pop,
    output logic [DW-1:0] wdata
);
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            stash_ins[8*i +: 8] = stash[8*i +: 8];
            if (i >= int'(fill) && i < int'(fill) + int'(rd_bytes))
                stash_ins[8*i +: 8] = rdata[8*(i - int'(fill)) +: 8];
            if (i + int'(wr_bytes) < NB)
                stash_pop[8*i +: 8] = stash[8*(i + int'(wr_bytes)) +: 8];
            else
                stash_pop[8*i +: 8] = 8'h00;
            wdata[8*i +: 8] = (i < int'(wr_bytes)) ? stash[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/dma_nest_chan.sv
module dma_nest_chan
    import dnc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int OFFW = 16,
    parameter int ITW  = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dsc_wr,
    input  logic [AW-1:0]   dsc_src,
    input  logic [AW-1:0]   dsc_dst,
    input  logic [OFFW-1:0] dsc_src_step,
    input  logic [OFFW-1:0] dsc_dst_step,
    input  logic [2:0]      dsc_src_size,
    input  logic [2:0]      dsc_dst_size,
    input  logic [31:0]     dsc_minor_bytes,
    input  logic [AW-1:0]   dsc_src_last,
    input  logic [AW-1:0]   dsc_dst_last,
    input  logic [ITW-1:0]  dsc_iter_cur,
    input  logic [ITW-1:0]  dsc_iter_begin,
    input  logic            dsc_irq_en,
    input  logic            dsc_start,
    input  logic            sw_start,
    input  logic            req_en,
    input  logic            hw_req,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [2:0]      mem_size,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            irq,
    output logic            err
);
    localparam int NB = DW / 8;
    localparam int CW = $clog2(NB) + 1;
    localparam int LW = 33;

    typedef struct packed {
        dnc_state_e      st;
        logic [AW-1:0]   sa;
        logic [AW-1:0]   da;
        logic [OFFW-1:0] soff;
        logic [OFFW-1:0] doff;
        logic [2:0]      ssz;
        logic [2:0]      dsz;
        logic [31:0]     nb;
        logic [AW-1:0]   slast;
        logic [AW-1:0]   dlast;
        logic [ITW-1:0]  citer;
        logic [ITW-1:0]  biter;
        logic            ien;
        logic            start;
        logic [LW-1:0]   left;
        logic [DW-1:0]   stash;
        logic [CW-1:0]   fill;
        logic            done;
        logic            irq;
        logic            err;
    } regs_t;

    regs_t q, d;

    logic [CW-1:0] sb, db;
    logic          s_ok, d_ok;
    logic [AW-1:0] sa_step, da_step, sa_end, da_end;
    logic [DW-1:0] stash_ins, stash_pop, wdata_c;
    logic          act, bad, misfit;
    logic          rd_c, wr_c;

    dnc_size_dec #(.NB(NB)) u_sdec (.code(q.ssz), .nbytes(sb), .ok(s_ok));
    dnc_size_dec #(.NB(NB)) u_ddec (.code(q.dsz), .nbytes(db), .ok(d_ok));

    dnc_addr_step #(.AW(AW), .OFFW(OFFW)) u_sa_step (.base(q.sa), .off(q.soff), .sum(sa_step));
    dnc_addr_step #(.AW(AW), .OFFW(OFFW)) u_da_step (.base(q.da), .off(q.doff), .sum(da_step));
    dnc_addr_step #(.AW(AW), .OFFW(AW))   u_sa_end  (.base(q.sa), .off(q.slast), .sum(sa_end));
    dnc_addr_step #(.AW(AW), .OFFW(AW))   u_da_end  (.base(da_step), .off(q.dlast), .sum(da_end));

    dnc_lane_buf #(.DW(DW)) u_lane (
        .stash(q.stash), .rdata(mem_rdata), .fill(q.fill),
        .rd_bytes(sb), .wr_bytes(db),
        .stash_ins(stash_ins), .stash_pop(stash_pop), .wdata(wdata_c)
    );

    always_comb begin
        d      = q;
        act    = (hw_req & req_en) | q.start;
        misfit = ((q.nb & 32'(sb - CW'(1))) != 32'd0) ||
                 ((q.nb & 32'(db - CW'(1))) != 32'd0);
        bad    = !s_ok || !d_ok || misfit;
        rd_c   = 1'b0;
        wr_c   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (dsc_wr) begin
                    d.sa    = dsc_src;
                    d.da    = dsc_dst;
                    d.soff  = dsc_src_step;
                    d.doff  = dsc_dst_step;
                    d.ssz   = dsc_src_size;
                    d.dsz   = dsc_dst_size;
                    d.nb    = dsc_minor_bytes;
                    d.slast = dsc_src_last;
                    d.dlast = dsc_dst_last;
                    d.citer = dsc_iter_cur;
                    d.biter = dsc_iter_begin;
                    d.ien   = dsc_irq_en;
                    d.start = dsc_start;
                    d.done  = 1'b0;
                    d.irq   = 1'b0;
                    d.err   = 1'b0;
                end else if (act) begin
                    if (bad) begin
                        d.err   = 1'b1;
                        d.start = 1'b0;
                    end else begin
                        d.st   = ST_XFER;
                        d.left = (q.nb == 32'd0) ? {1'b1, 32'd0} : {1'b0, q.nb};
                        d.fill = '0;
                        d.done = 1'b0;
                        d.irq  = 1'b0;
                        d.err  = 1'b0;
                    end
                end
            end
            ST_XFER: begin
                if (q.fill >= db) begin
                    wr_c    = 1'b1;
                    d.da    = da_step;
                    d.stash = stash_pop;
                    d.fill  = q.fill - db;
                    d.left  = q.left - LW'(db);
                    if (q.left == LW'(db)) begin
                        d.st = ST_IDLE;
                        if (q.citer <= ITW'(1)) begin
                            d.sa    = sa_end;
                            d.da    = da_end;
                            d.citer = q.biter;
                            d.done  = 1'b1;
                            d.irq   = q.ien;
                            d.start = 1'b0;
                        end else begin
                            d.citer = q.citer - ITW'(1);
                        end
                    end
                end else begin
                    rd_c = 1'b1;
                    d.sa = sa_step;
                    d.st = ST_RDW;
                end
            end
            ST_RDW: begin
                d.stash = stash_ins;
                d.fill  = q.fill + sb;
                d.st    = ST_XFER;
            end
            default: d.st = ST_IDLE;
        endcase
        if (sw_start) d.start = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd    = rd_c;
    assign mem_wr    = wr_c;
    assign mem_addr  = wr_c ? q.da : q.sa;
    assign mem_size  = wr_c ? q.dsz : q.ssz;
    assign mem_wdata = wdata_c;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign irq       = q.irq;
    assign err       = q.err;
endmodule

// File: rtl/dnc_chk.sv
module dnc_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic busy,
    input logic done,
    input logic irq,
    input logic err
);
    assert_rw_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_wr));

    assert_err_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !$past(busy));

    assert_err_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!mem_rd && !mem_wr));
endmodule

bind dma_nest_chan dnc_chk u_dnc_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .busy(busy), .done(done), .irq(irq), .err(err)
);

// File: tb/dma_nest_chan_tb_top.sv
module dma_nest_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dsc_wr = 1'b0;
    logic [31:0] dsc_src = '0, dsc_dst = '0;
    logic [15:0] dsc_src_step = '0, dsc_dst_step = '0;
    logic [2:0]  dsc_src_size = '0, dsc_dst_size = '0;
    logic [31:0] dsc_minor_bytes = '0;
    logic [31:0] dsc_src_last = '0, dsc_dst_last = '0;
    logic [14:0] dsc_iter_cur = '0, dsc_iter_begin = '0;
    logic        dsc_irq_en = 1'b0, dsc_start = 1'b0;
    logic        sw_start = 1'b0, req_en = 1'b0, hw_req = 1'b0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, irq, err;

    int checks = 0;
    int errors = 0;

    logic [7:0]  wmem [256];
    int          nrd = 0, nwr = 0;
    logic [31:0] ra [64];
    logic [31:0] wa [64];
    logic [2:0]  rsz_last = '0, wsz_last = '0;
    logic        log_clr = 1'b0;

    always #5 clk = ~clk;

    dma_nest_chan dut_i (
        .clk(clk), .rst_n(rst_n), .dsc_wr(dsc_wr), .dsc_src(dsc_src), .dsc_dst(dsc_dst),
        .dsc_src_step(dsc_src_step), .dsc_dst_step(dsc_dst_step),
        .dsc_src_size(dsc_src_size), .dsc_dst_size(dsc_dst_size),
        .dsc_minor_bytes(dsc_minor_bytes), .dsc_src_last(dsc_src_last),
        .dsc_dst_last(dsc_dst_last), .dsc_iter_cur(dsc_iter_cur),
        .dsc_iter_begin(dsc_iter_begin), .dsc_irq_en(dsc_irq_en), .dsc_start(dsc_start),
        .sw_start(sw_start), .req_en(req_en), .hw_req(hw_req),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .irq(irq), .err(err)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // memory model: source bytes from pat(), writes land in wmem
    always @(posedge clk) begin
        if (log_clr) begin
            nrd <= 0;
            nwr <= 0;
            for (int i = 0; i < 256; i++) wmem[i] <= 8'h00;
        end else begin
            if (mem_rd) begin
                for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] <= pat(mem_addr + 32'(b));
                if (nrd < 64) ra[nrd] <= mem_addr;
                rsz_last <= mem_size;
                nrd <= nrd + 1;
            end
            if (mem_wr) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    wmem[(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
                if (nwr < 64) wa[nwr] <= mem_addr;
                wsz_last <= mem_size;
                nwr <= nwr + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] dd, input logic [15:0] so,
                        input logic [15:0] dof, input logic [2:0] ssz, input logic [2:0] dsz,
                        input logic [31:0] nb, input logic [31:0] sl, input logic [31:0] dl,
                        input logic [14:0] it, input logic ien, input logic st);
        @(negedge clk);
        dsc_src = s; dsc_dst = dd; dsc_src_step = so; dsc_dst_step = dof;
        dsc_src_size = ssz; dsc_dst_size = dsz; dsc_minor_bytes = nb;
        dsc_src_last = sl; dsc_dst_last = dl; dsc_iter_cur = it; dsc_iter_begin = it;
        dsc_irq_en = ien; dsc_start = st; dsc_wr = 1'b1;
        @(negedge clk) dsc_wr = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk) hw_req = 1'b1;
        @(negedge clk) hw_req = 1'b0;
        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", err, 0);
        chk("R1 rd/wr", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_major_adjust();
        req_en = 1'b1;
        clr_log();
        load(32'h10, 32'h80, 16'd1, 16'd1, 3'd0, 3'd0, 32'd4, -32'sd8, 32'h10, 15'd2, 1'b1, 1'b0);
        pulse_req();
        chk("R2 writes per minor", nwr, 4);
        chk("R2 idle after minor", busy, 0);
        chk("R7 not done after first", done, 0);
        chk("R3 read step", ra[3], 32'h13);
        chk("R3 write step", wa[3], 32'h83);
        pulse_req();
        chk("R8 done", done, 1);
        chk("R8 irq enabled", irq, 1);
        for (int k = 0; k < 8; k++) chk("R4 byte copy", wmem[8'h80 + 8'(k)], pat(32'h10 + 32'(k)));
        pulse_req();
        chk("R6 source correction", ra[8], 32'h10);
        chk("R6 dest correction", wa[8], 32'h98);
        chk("R8 done cleared on start", done, 0);
        chk("R7 reload not done", done, 0);
        pulse_req();
        chk("R7 reload done after begin count", done, 1);
    endtask

    task automatic t_pack();
        clr_log();
        load(32'h20, 32'h40, 16'd1, 16'd4, 3'd0, 3'd2, 32'd8, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        pulse_req();
        chk("R4 pack reads", nrd, 8);
        chk("R4 pack writes", nwr, 2);
        chk("R4 read size code", rsz_last, 0);
        chk("R4 write size code", wsz_last, 2);
        chk("R8 no irq when disabled", irq, 0);
        for (int k = 0; k < 8; k++) chk("R4 pack data", wmem[8'h40 + 8'(k)], pat(32'h20 + 32'(k)));
        pulse_req();
        chk("R6 zero correction keeps source", ra[8], 32'h28);
    endtask

    task automatic t_split();
        clr_log();
        load(32'h60, 32'hA0, 16'd4, 16'd1, 3'd2, 3'd0, 32'd8, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        pulse_req();
        chk("R4 split reads", nrd, 2);
        chk("R4 split writes", nwr, 8);
        for (int k = 0; k < 8; k++) chk("R4 split data", wmem[8'hA0 + 8'(k)], pat(32'h60 + 32'(k)));
    endtask

    task automatic t_negstep();
        clr_log();
        load(32'h40, 32'h90, -16'sd2, 16'd2, 3'd1, 3'd1, 32'd8, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        pulse_req();
        for (int i = 0; i < 4; i++) begin
            chk("R3 negative source step", ra[i], 32'h40 - 32'(2*i));
            chk("R3 dest step", wa[i], 32'h90 + 32'(2*i));
            chk("R3 halfword lo", wmem[8'h90 + 8'(2*i)], pat(32'h40 - 32'(2*i)));
            chk("R3 halfword hi", wmem[8'h91 + 8'(2*i)], pat(32'h41 - 32'(2*i)));
        end
    endtask

    task automatic t_reqen();
        clr_log();
        load(32'h00, 32'hB0, 16'd1, 16'd1, 3'd0, 3'd0, 32'd2, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        req_en = 1'b0;
        pulse_req();
        repeat (10) @(negedge clk);
        chk("R10 masked request no read", nrd, 0);
        chk("R10 masked request idle", busy, 0);
        req_en = 1'b1;
        pulse_req();
        chk("R10 enabled request runs", nwr, 2);
    endtask

    task automatic t_swstart();
        clr_log();
        req_en = 1'b0;
        load(32'h50, 32'hD0, 16'd1, 16'd1, 3'd0, 3'd0, 32'd2, 32'd0, 32'd0, 15'd3, 1'b0, 1'b0);
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
        repeat (100) @(negedge clk);
        chk("R9 whole major loop", nwr, 6);
        chk("R9 done", done, 1);
        chk("R8 irq stays low", irq, 0);
        repeat (20) @(negedge clk);
        chk("R9 start cleared", nwr, 6);
        req_en = 1'b1;
    endtask

    task automatic t_err();
        clr_log();
        load(32'h00, 32'hB0, 16'd2, 16'd2, 3'd1, 3'd1, 32'd3, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        pulse_req();
        @(negedge clk);
        chk("R11 misfit count err", err, 1);
        chk("R11 no access", nrd + nwr, 0);
        load(32'h00, 32'hB0, 16'd1, 16'd1, 3'd3, 3'd0, 32'd4, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        chk("R12 descriptor write clears err", err, 0);
        pulse_req();
        @(negedge clk);
        chk("R11 bad size code err", err, 1);
        chk("R11 no access bad size", nrd + nwr, 0);
    endtask

    task automatic t_busy_write();
        clr_log();
        load(32'h20, 32'hC0, 16'd1, 16'd1, 3'd0, 3'd0, 32'd16, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        @(negedge clk) hw_req = 1'b1;
        @(negedge clk) hw_req = 1'b0;
        repeat (5) @(negedge clk);
        dsc_dst = 32'h00; dsc_minor_bytes = 32'd2; dsc_wr = 1'b1;
        @(negedge clk) dsc_wr = 1'b0;
        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
        chk("R12 ignored write count", nwr, 16);
        chk("R12 ignored write dest", wa[15], 32'hCF);
        chk("R12 done before clear", done, 1);
        load(32'h20, 32'hC0, 16'd1, 16'd1, 3'd0, 3'd0, 32'd16, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        chk("R12 idle write clears done", done, 0);
    endtask

    task automatic t_zero_count();
        clr_log();
        load(32'h00, 32'h00, 16'd4, 16'd4, 3'd2, 3'd2, 32'd0, 32'd0, 32'd0, 15'd1, 1'b0, 1'b0);
        @(negedge clk) hw_req = 1'b1;
        @(negedge clk) hw_req = 1'b0;
        repeat (300) @(negedge clk);
        chk("R5 still busy", busy, 1);
        chk("R5 many writes", (nwr >= 90), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_major_adjust();
                t_pack();
                t_split();
                t_negstep();
                t_reqen();
                t_swstart();
                t_err();
                t_busy_write();
                t_zero_count();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule